// File: doc/BRIEF.md
# Windowed Dot-Product Engine with Local Reuse Buffer

The engine computes a sliding weighted sum over a long sample stream held in a large, slow memory. Each result `y[i]` is the sum over `j = 0..TAPS-1` of `x[i+j] * w[j]`. A run of `MAX` samples gives `MAX-TAPS+1` results. The memory is reached through a pipelined read port. Each read returns one block of `LANES` consecutive 16-bit words after a fixed latency. A new read can be issued every cycle.

The fetch sequencer reads the weight block once, at the start of a run. It then reads each sample block exactly once and runs ahead of the arithmetic, up to the capacity of a small ring buffer. All repeated uses of a sample are served from that buffer. The multiply-accumulate stage produces one result per cycle. It waits only when a sample it needs has not yet arrived, or when the consumer holds back `out_ready`.

A `start` pulse begins a run. A one-cycle `done` pulse follows acceptance of the last result.

Top module: `wdot_top`

## Requirements
- R1: With `out_ready` held high, the block emits exactly `MAX-TAPS+1` results per run, in index order, and result `i` equals the sum over `j` of `x[i+j]*w[j]`. Both operands are signed 16-bit.
- R2: Each run issues exactly one read at address `W_ADDR`. Weight `w[j]` is taken from lane `j` of that response, where lane `j` is bits `[16j+15:16j]`.
- R3: Sample block `b` is read from address `X_ADDR+b`, and it holds `x[8b+l]` in lane `l`. Each block `0..ceil(MAX/8)-1` is read exactly once per run, and no other address is read.
- R4: Results are exact over the whole signed input range. With every sample and weight at -32768, each result is 5*2^30, carried in a 35-bit signed output.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` stay unchanged. No result is lost or duplicated under any pattern of `out_ready`.
- R6: `done` is a single-cycle pulse. It rises in the cycle after the last result is accepted, and there is exactly one per run.
- R7: A `start` pulse during a run is ignored. The run's results and reads are unchanged.
- R8: With default parameters and `out_ready` high, `done` arrives within 130 cycles of `start`. A schedule that waited out each 20-cycle read would need well over 250 cycles.
- R9: After reset, `out_valid`, `mem_req` and `done` are low.
- R10: The local buffer holds at most `BUF_BLK` (5) sample blocks. While results are held back by the consumer, the block stops reading once the buffer is full. With default parameters and `out_ready` held low from the start of a run, exactly 6 reads are issued: the weight block plus 5 sample blocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begins a run when idle |
| done | output | 1 | One-cycle pulse after the last result is accepted |
| mem_req | output | 1 | Read request strobe to the large memory |
| mem_addr | output | AW | Block address of the request |
| mem_rvalid | input | 1 | Read response valid, in request order |
| mem_rdata | input | LANES*DW | Response block, lane `l` in bits `[16l+15:16l]` |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer accepts the result |
| out_data | output | 2*DW+3 | Signed result |

## Verification
A wrong fill slot or head pointer mixes samples from the wrong block into the window. The very first result that spans the damaged words then shows a wrong sum, so some result within one buffer's worth of indices differs from the bench's own arithmetic. A wrong fetch limit shows up in the memory port's address trace within the first few dozen cycles: either a block is read twice, or the read count under a stalled consumer differs from six. A broken handshake or completion flag shows up as a changed held result, a missing or extra result, or a `done` pulse that comes early, is missing, or is doubled.

// File: rtl/wdot_pkg.sv
package wdot_pkg;
  localparam int unsigned SAMPLE_W  = 16;
  localparam int unsigned BLK_LANES = 8;
  localparam int unsigned NUM_TAPS  = 5;
  localparam int unsigned RING_BLKS = 5;
endpackage

// File: rtl/wdot_fetch.sv
module wdot_fetch #(
  parameter int unsigned NBLK    = 12,
  parameter int unsigned BUF_BLK = 5,
  parameter int unsigned AW      = 16,
  parameter int unsigned CW      = 9,
  parameter logic [AW-1:0] W_ADDR = '0,
  parameter logic [AW-1:0] X_ADDR = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_run,
  input  logic          run,
  input  logic [CW-1:0] low_blk,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr
);
  logic [CW-1:0] req_cnt, req_cnt_n;
  logic [CW-1:0] x_idx, x_lim;
  logic          can_x, more, issue;

  always_comb begin
    x_idx = req_cnt - CW'(1);
    x_lim = low_blk + CW'(BUF_BLK);
    can_x = (req_cnt == '0) || (x_idx < x_lim);
    more  = (req_cnt <= CW'(NBLK));
    issue = run && more && can_x;
    req_cnt_n = req_cnt;
    if (start_run)  req_cnt_n = '0;
    else if (issue) req_cnt_n = req_cnt + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_cnt <= '0;
    else        req_cnt <= req_cnt_n;
  end

  assign mem_req  = issue;
  assign mem_addr = (req_cnt == '0) ? W_ADDR : (X_ADDR + AW'(x_idx));
endmodule

// File: rtl/wdot_lbuf.sv
module wdot_lbuf #(
  parameter int unsigned DW      = 16,
  parameter int unsigned LANES   = 8,
  parameter int unsigned TAPS    = 5,
  parameter int unsigned BUF_BLK = 5,
  parameter int unsigned CW      = 9,
  parameter int unsigned PW      = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_run,
  input  logic                  rvalid,
  input  logic [LANES*DW-1:0]   rdata,
  input  logic [PW-1:0]         head,
  output logic                  w_ok,
  output logic [CW-1:0]         arr_cnt,
  output logic [TAPS*DW-1:0]    taps,
  output logic [TAPS*DW-1:0]    weights
);
  localparam int unsigned DEPTH = BUF_BLK * LANES;
  localparam int unsigned IXW   = PW - 1;
  localparam int unsigned SW    = $clog2(BUF_BLK);

  logic [DW-1:0] xbuf [DEPTH];
  logic [DW-1:0] wreg [TAPS];
  logic [SW-1:0] ws, ws_n;
  logic [CW-1:0] arr_cnt_n;
  logic          w_ok_n, wr_w, wr_x;

  always_comb begin
    wr_w      = rvalid && !w_ok;
    wr_x      = rvalid && w_ok;
    w_ok_n    = w_ok;
    ws_n      = ws;
    arr_cnt_n = arr_cnt;
    if (start_run) begin
      w_ok_n    = 1'b0;
      ws_n      = '0;
      arr_cnt_n = '0;
    end else if (wr_w) begin
      w_ok_n = 1'b1;
    end else if (wr_x) begin
      ws_n      = (ws == SW'(BUF_BLK-1)) ? '0 : ws + SW'(1);
      arr_cnt_n = arr_cnt + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_ok    <= 1'b0;
      ws      <= '0;
      arr_cnt <= '0;
    end else begin
      w_ok    <= w_ok_n;
      ws      <= ws_n;
      arr_cnt <= arr_cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_x) begin
      for (int l = 0; l < LANES; l++)
        xbuf[IXW'(ws) * IXW'(LANES) + IXW'(l)] <= rdata[l*DW +: DW];
    end
  end

  always_ff @(posedge clk) begin
    if (wr_w) begin
      for (int j = 0; j < TAPS; j++)
        wreg[j] <= rdata[j*DW +: DW];
    end
  end

  for (genvar j = 0; j < TAPS; j++) begin : g_tap
    logic [PW-1:0] pos;
    always_comb begin
      pos = head + PW'(j);
      if (pos >= PW'(DEPTH)) pos = pos - PW'(DEPTH);
    end
    assign taps[j*DW +: DW]    = xbuf[pos[IXW-1:0]];
    assign weights[j*DW +: DW] = wreg[j];
  end
endmodule

// File: rtl/wdot_mac.sv
module wdot_mac #(
  parameter int unsigned DW      = 16,
  parameter int unsigned LANES   = 8,
  parameter int unsigned TAPS    = 5,
  parameter int unsigned MAX     = 96,
  parameter int unsigned BUF_BLK = 5,
  parameter int unsigned CW      = 9,
  parameter int unsigned PW      = 7,
  parameter int unsigned ACCW    = 35
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                w_ok,
  input  logic [CW-1:0]       arr_cnt,
  input  logic [TAPS*DW-1:0]  taps,
  input  logic [TAPS*DW-1:0]  weights,
  input  logic                out_ready,
  output logic                run,
  output logic                start_run,
  output logic [PW-1:0]       head,
  output logic [CW-1:0]       low_blk,
  output logic                out_valid,
  output logic [ACCW-1:0]     out_data,
  output logic                done
);
  localparam int unsigned NOUT  = MAX - TAPS + 1;
  localparam int unsigned DEPTH = BUF_BLK * LANES;
  localparam int unsigned LB    = $clog2(LANES);

  logic [CW-1:0]   idx, idx_n, need_blk;
  logic [PW-1:0]   head_n;
  logic            run_n, ov_n, olast, olast_n, done_n, have, fire;
  logic [ACCW-1:0] od_n, acc;

  always_comb begin
    acc = '0;
    for (int j = 0; j < TAPS; j++) begin
      logic signed [2*DW-1:0] p;
      p   = $signed(taps[j*DW +: DW]) * $signed(weights[j*DW +: DW]);
      acc = acc + {{(ACCW-2*DW){p[2*DW-1]}}, p};
    end
  end

  always_comb begin
    start_run = start && !run;
    need_blk  = (idx + CW'(TAPS-1)) >> LB;
    have      = arr_cnt > need_blk;
    fire      = run && w_ok && (idx < CW'(NOUT)) && have && (!out_valid || out_ready);
    done_n    = out_valid && out_ready && olast;
    run_n     = run;
    idx_n     = idx;
    head_n    = head;
    ov_n      = out_valid;
    od_n      = out_data;
    olast_n   = olast;
    if (start_run) begin
      run_n  = 1'b1;
      idx_n  = '0;
      head_n = '0;
    end else if (done_n) begin
      run_n = 1'b0;
    end
    if (fire) begin
      idx_n   = idx + CW'(1);
      head_n  = (head == PW'(DEPTH-1)) ? '0 : head + PW'(1);
      ov_n    = 1'b1;
      od_n    = acc;
      olast_n = (idx == CW'(NOUT-1));
    end else if (out_valid && out_ready) begin
      ov_n    = 1'b0;
      olast_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run       <= 1'b0;
      idx       <= '0;
      head      <= '0;
      out_valid <= 1'b0;
      olast     <= 1'b0;
      done      <= 1'b0;
    end else begin
      run       <= run_n;
      idx       <= idx_n;
      head      <= head_n;
      out_valid <= ov_n;
      olast     <= olast_n;
      done      <= done_n;
    end
  end

  always_ff @(posedge clk) begin
    if (fire) out_data <= od_n;
  end

  assign low_blk = idx >> LB;
endmodule

// File: rtl/wdot_top.sv
module wdot_top
  import wdot_pkg::*;
#(
  parameter int unsigned DW      = SAMPLE_W,
  parameter int unsigned LANES   = BLK_LANES,
  parameter int unsigned TAPS    = NUM_TAPS,
  parameter int unsigned MAX     = 96,
  parameter int unsigned BUF_BLK = RING_BLKS,
  parameter int unsigned AW      = 16,
  parameter logic [AW-1:0] W_ADDR = 16'h0100,
  parameter logic [AW-1:0] X_ADDR = 16'h0200,
  localparam int unsigned ACCW   = 2*DW + $clog2(TAPS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  output logic                done,
  output logic                mem_req,
  output logic [AW-1:0]       mem_addr,
  input  logic                mem_rvalid,
  input  logic [LANES*DW-1:0] mem_rdata,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [ACCW-1:0]     out_data
);
  localparam int unsigned NBLK = (MAX + LANES - 1) / LANES;
  localparam int unsigned CW   = $clog2(MAX + LANES*BUF_BLK + 2*TAPS) + 1;
  localparam int unsigned PW   = $clog2(LANES*BUF_BLK) + 1;

  logic [1:0]         rst_sync;
  logic               rst_sn;
  logic               run, start_run, w_ok;
  logic [CW-1:0]      low_blk, arr_cnt;
  logic [PW-1:0]      head;
  logic [TAPS*DW-1:0] taps, weights;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sn = rst_sync[1];

  wdot_fetch #(.NBLK(NBLK), .BUF_BLK(BUF_BLK), .AW(AW), .CW(CW),
               .W_ADDR(W_ADDR), .X_ADDR(X_ADDR)) u_fetch (
    .clk(clk), .rst_n(rst_sn), .start_run(start_run), .run(run),
    .low_blk(low_blk), .mem_req(mem_req), .mem_addr(mem_addr));

  wdot_lbuf #(.DW(DW), .LANES(LANES), .TAPS(TAPS), .BUF_BLK(BUF_BLK),
              .CW(CW), .PW(PW)) u_lbuf (
    .clk(clk), .rst_n(rst_sn), .start_run(start_run), .rvalid(mem_rvalid),
    .rdata(mem_rdata), .head(head), .w_ok(w_ok), .arr_cnt(arr_cnt),
    .taps(taps), .weights(weights));

  wdot_mac #(.DW(DW), .LANES(LANES), .TAPS(TAPS), .MAX(MAX), .BUF_BLK(BUF_BLK),
             .CW(CW), .PW(PW), .ACCW(ACCW)) u_mac (
    .clk(clk), .rst_n(rst_sn), .start(start), .w_ok(w_ok), .arr_cnt(arr_cnt),
    .taps(taps), .weights(weights), .out_ready(out_ready), .run(run),
    .start_run(start_run), .head(head), .low_blk(low_blk),
    .out_valid(out_valid), .out_data(out_data), .done(done));
endmodule

// File: rtl/wdot_chk.sv
module wdot_chk #(
  parameter int unsigned NBLK    = 12,
  parameter int unsigned BUF_BLK = 5,
  parameter int unsigned CW      = 9,
  parameter int unsigned ACCW    = 35
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start_run,
  input logic            run,
  input logic            mem_req,
  input logic            out_valid,
  input logic            out_ready,
  input logic [ACCW-1:0] out_data,
  input logic            done,
  input logic [CW-1:0]   arr_cnt,
  input logic [CW-1:0]   low_blk
);
  logic [CW-1:0] req_tot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        req_tot <= '0;
    else if (start_run) req_tot <= '0;
    else if (mem_req)   req_tot <= req_tot + CW'(1);
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R5
  AST_REQ_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> run); // R3
  AST_READ_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    req_tot <= CW'(NBLK + 1)); // R3
  AST_RING_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    arr_cnt <= low_blk + CW'(BUF_BLK)); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(out_valid && out_ready)); // R6
endmodule

bind wdot_top wdot_chk #(.NBLK(NBLK), .BUF_BLK(BUF_BLK), .CW(CW), .ACCW(ACCW)) u_chk (
  .clk(clk), .rst_n(rst_sn), .start_run(start_run), .run(run),
  .mem_req(mem_req), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .done(done), .arr_cnt(arr_cnt), .low_blk(low_blk));

// File: tb/wdot_top_bench.sv
`timescale 1ns/1ps
module wdot_top_bench;
  localparam int MAX = 96, TAPS = 5, LANES = 8, BUF_BLK = 5, LAT = 20;
  localparam int NOUT = MAX - TAPS + 1;
  localparam int NBLK = (MAX + LANES - 1) / LANES;
  localparam logic [15:0] WA = 16'h0100, XA = 16'h0200;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, out_ready = 1'b1;
  logic done, mem_req, mem_rvalid, out_valid;
  logic [15:0] mem_addr;
  logic [127:0] mem_rdata;
  logic [34:0] out_data;

  int nchk = 0, nerr = 0, cyc = 0, dmode = 0, rmode = 0;
  int got_n, done_cnt, outs_at_done, done_cyc, req_tot, bad_addr, hold_bad;
  int whit;
  int xhit [NBLK];
  longint gotv [128];
  logic hold_prev = 1'b0;
  logic [34:0] hold_d;
  logic pv [LAT];
  logic [15:0] pa [LAT];

  wdot_top #(.MAX(MAX)) u_wdot_top (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data));

  always #10 clk = ~clk;

  function automatic longint xv(int m, int k);
    if (m == 1) return -32768;
    if (m == 2) return (k % 2 == 0) ? 32767 : -32768;
    return ((k * 37 + 11) % 201) - 100;
  endfunction

  function automatic longint wv(int m, int j);
    if (m == 1) return -32768;
    if (m == 2) return (j % 2 == 0) ? 32767 : -32768;
    case (j)
      0: return 3;  1: return -2;  2: return 5;  3: return 1;  default: return -4;
    endcase
  endfunction

  function automatic logic [127:0] mdata(logic [15:0] a);
    logic [127:0] d = '0;
    for (int l = 0; l < LANES; l++) begin
      logic [15:0] v = 16'h0;
      if (a == WA && l < TAPS) v = 16'(wv(dmode, l));
      else if (a >= XA && a < XA + NBLK) v = 16'(xv(dmode, int'(a - XA) * LANES + l));
      d[l*16 +: 16] = v;
    end
    return d;
  endfunction

  initial for (int k = 0; k < LAT; k++) begin pv[k] = 1'b0; pa[k] = '0; end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    pv[0] <= mem_req;
    pa[0] <= mem_addr;
    for (int k = 1; k < LAT; k++) begin pv[k] <= pv[k-1]; pa[k] <= pa[k-1]; end
    if (mem_req) begin
      req_tot = req_tot + 1;
      if (mem_addr == WA) whit = whit + 1;
      else if (mem_addr >= XA && mem_addr < XA + NBLK) xhit[mem_addr - XA] = xhit[mem_addr - XA] + 1;
      else bad_addr = bad_addr + 1;
    end
  end
  assign mem_rvalid = pv[LAT-1];
  assign mem_rdata  = mdata(pa[LAT-1]);

  always @(posedge clk) begin
    #1;
    case (rmode)
      1:       out_ready = (cyc % 3 != 2);
      2:       out_ready = 1'b0;
      default: out_ready = 1'b1;
    endcase
  end

  always @(negedge clk) begin
    if (hold_prev && !(out_valid && out_data == hold_d)) hold_bad = hold_bad + 1;
    hold_prev = out_valid && !out_ready;
    hold_d    = out_data;
    if (out_valid && out_ready) begin
      if (got_n < 128) gotv[got_n] = longint'($signed(out_data));
      got_n = got_n + 1;
    end
    if (done) begin
      done_cnt = done_cnt + 1;
      outs_at_done = got_n;
      done_cyc = cyc;
    end
  end

  task automatic chk(bit ok, string req, longint act, longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_case(int mode, int rm, bit restart, bit stall, string tag);
    int t0, bad, first_bad;
    longint e, first_exp, first_got;
    dmode = mode;
    got_n = 0; done_cnt = 0; outs_at_done = 0; req_tot = 0; bad_addr = 0;
    hold_bad = 0; whit = 0;
    for (int b = 0; b < NBLK; b++) xhit[b] = 0;
    rmode = stall ? 2 : rm;
    @(posedge clk); #2 start = 1'b1; t0 = cyc;
    @(posedge clk); #2 start = 1'b0;
    if (stall) begin
      repeat (100) @(negedge clk);
      chk(req_tot == 1 + BUF_BLK, "R10 reads while stalled", req_tot, 1 + BUF_BLK);
      rmode = rm;
    end
    if (restart) begin
      repeat (40) @(posedge clk);
      #2 start = 1'b1; @(posedge clk); #2 start = 1'b0;
    end
    while (done_cnt == 0 && cyc < t0 + 3000) @(negedge clk);
    repeat (40) @(negedge clk);
    bad = 0; first_bad = -1; first_exp = 0; first_got = 0;
    for (int i = 0; i < NOUT && i < got_n; i++) begin
      e = 0;
      for (int j = 0; j < TAPS; j++) e += xv(mode, i + j) * wv(mode, j);
      if (gotv[i] != e) begin
        if (first_bad < 0) begin first_bad = i; first_exp = e; first_got = gotv[i]; end
        bad++;
      end
    end
    chk(got_n == NOUT, {tag, " result count"}, got_n, NOUT);
    chk(bad == 0, {tag, " result value"}, first_got, first_exp);
    chk(done_cnt == 1, "R6 done pulses", done_cnt, 1);
    chk(outs_at_done == NOUT, "R6 results before done", outs_at_done, NOUT);
    chk(whit == 1, "R2 weight reads", whit, 1);
    for (int b = 0; b < NBLK; b++)
      if (xhit[b] != 1) chk(1'b0, "R3 block read count", xhit[b], 1);
    chk(req_tot == NBLK + 1 && bad_addr == 0, "R3 total reads", req_tot, NBLK + 1);
    if (rm == 1) chk(hold_bad == 0, "R5 held result changed", hold_bad, 0);
    if (rm == 0 && !stall && !restart)
      chk(done_cyc - t0 <= 130, "R8 run length", done_cyc - t0, 130);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog R1 actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!out_valid && !mem_req && !done, "R9 reset state",
        {out_valid, mem_req, done}, 0);
    run_case(0, 0, 1'b0, 1'b0, "R1");
    run_case(1, 0, 1'b0, 1'b0, "R4");
    run_case(2, 1, 1'b0, 1'b0, "R5");
    run_case(0, 0, 1'b1, 1'b0, "R7");
    run_case(2, 0, 1'b0, 1'b1, "R10");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule